// File: doc/BRIEF.md
# Trace Branch-Target Nibble Serializer

This block turns per-cycle retirement events from a processor core into a real-time trace. The trace uses two 4-bit output ports. The status port (`pst_o`) reports one code per clock. The data port (`ddata_o`) streams captured payload bytes one nibble per clock.

The core presents exactly one event kind every cycle:
- a plain status code;
- a taken branch with a fixed target;
- a taken branch with a computed target;
- a debug data write.

A computed-target branch first reports the branch code. On the next clock it reports a marker that gives how many low-order target bytes follow. A data write reports its marker at once. Payload nibbles wait in a small queue, so the status port can keep reporting later instructions while earlier nibbles drain.

When a payload does not fit in the free queue space, the block raises `stall_o`. It then shows the idle code until there is room. A payload is always queued whole, never split. While `stall_o` is high the core holds its event unchanged, and that event is taken on the first clock with `stall_o` low.

Top module: `trc_nib_serializer`

## Requirements
- R1: A synchronous reset with `rst_n` low clears the queue. It drives `pst_o` and `ddata_o` to 0x0, and `stall_o` to 0 when a plain status event is presented.
- R2: A status event (`ev_kind_i` = 0) accepted on a clock edge makes `pst_o` equal `ev_code_i` for the following cycle.
- R3: A taken-branch event accepted on a clock edge makes `pst_o` show 0x5 for the following cycle. This covers both fixed-target (`ev_kind_i` = 1) and computed-target (`ev_kind_i` = 2) branches. A fixed-target branch queues no nibbles.
- R4: After a computed-target branch, `stall_o` is high during the cycle that shows 0x5. On the next edge, if the payload fits, `pst_o` shows a marker for the byte count set by `cfg_tgt_bytes_i` as sampled with the branch:
  - 0 selects 2 bytes, marker 0x9;
  - 1 selects 3 bytes, marker 0xA;
  - 2 or 3 selects 4 bytes, marker 0xB.
- R5: Queued nibbles leave on `ddata_o` one per clock, least significant nibble first, and only the selected low-order bytes of the address are sent. When the queue is empty at the moment a payload is pushed, the first nibble appears in the same cycle as its marker.
- R6: A data-write event (`ev_kind_i` = 3) that fits shows its marker on `pst_o` the next cycle and queues the low bytes of `ev_addr_i`. The size comes from `wr_size_i`:
  - 0 gives 1 byte, marker 0x8;
  - 1 gives 2 bytes, marker 0x9;
  - 2 or 3 gives 4 bytes, marker 0xB.
- R7: Payloads drain in the order they were accepted. Status and branch codes keep appearing on `pst_o` while earlier nibbles are still being sent.
- R8: A payload is pushed only when its whole nibble count fits in the 16-nibble queue's free space, measured before that cycle's pop. While a payload waits for room, `stall_o` is high and `pst_o` shows 0x0.
- R9: `ddata_o` is 0x0 in every cycle in which no nibble is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_kind_i | input | 2 | Event kind: 0 status, 1 fixed branch, 2 computed branch, 3 data write |
| ev_code_i | input | 4 | Status code shown for a status event |
| ev_addr_i | input | 32 | Branch target or write data |
| cfg_tgt_bytes_i | input | 2 | Target byte count select (0:2, 1:3, else 4) |
| wr_size_i | input | 2 | Write operand size (0:1 byte, 1:2, else 4) |
| pst_o | output | 4 | Trace status code |
| ddata_o | output | 4 | Payload nibble, 0x0 when idle |
| stall_o | output | 1 | Core must hold its current event |

## Verification
The bench builds the block with its default 16-nibble queue and 32-bit address. With these values, two back-to-back 4-byte writes leave only a nibble or two free. That puts the full-queue stall, the idle code and the resumed marker within reach after a handful of cycles. Random events with every target-size and write-size setting then exercise:
- the wrap-around of the queue pointers;
- markers waiting behind a queue still draining;
- status codes interleaved with draining payloads.

// File: rtl/trc_pkg.sv
// Package: shared event kinds, fixed trace codes and byte-count helpers.
// Assumes one event kind per cycle and a byte-count range of 1 to 4.
package trc_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        EV_STATUS  = 2'd0,
        EV_BR_FIX  = 2'd1,
        EV_BR_COMP = 2'd2,
        EV_DWRITE  = 2'd3
    } ev_kind_t;

    localparam logic [NIB_W-1:0] PST_IDLE   = 4'h0;
    localparam logic [NIB_W-1:0] PST_BRANCH = 4'h5;
    localparam logic [NIB_W-1:0] MARK_BASE  = 4'h7;

    // Number of target bytes selected by the configuration field.
    function automatic logic [2:0] tgt_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    // Number of data bytes for a write operand size.
    function automatic logic [2:0] wr_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Marker code announcing a payload of the given byte count.
    function automatic logic [NIB_W-1:0] marker_for(input logic [2:0] nbytes);
        return MARK_BASE + {1'b0, nbytes};
    endfunction

endpackage

// File: rtl/trc_payload_fmt.sv
// Payload formatter: derives the nibble count and marker code of the
// payload that the current event would queue.
// Assumes ADDR_W holds at least four bytes; the output only matters for
// computed branches and data writes.
module trc_payload_fmt
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int MAX_NIB = ADDR_W / NIB_W,
    localparam int NN_W = $clog2(MAX_NIB + 1)
) (
    input  ev_kind_t           kind_i,
    input  logic [1:0]         cfg_tgt_bytes_i,
    input  logic [1:0]         wr_size_i,
    output logic [NN_W-1:0]    nnib_o,
    output logic [NIB_W-1:0]   marker_o
);

    logic [2:0] nbytes;

    // Choose the byte count from the event kind.
    always_comb begin
        if (kind_i == EV_DWRITE) begin
            nbytes = wr_bytes(wr_size_i);
        end else begin
            nbytes = tgt_bytes(cfg_tgt_bytes_i);
        end
    end

    // Two nibbles per byte, marker from the byte count.
    always_comb begin
        nnib_o   = NN_W'({nbytes, 1'b0});
        marker_o = marker_for(nbytes);
    end

endmodule

// File: rtl/trc_nib_fifo.sv
// Nibble queue: accepts up to MAX_NIB nibbles in one push, low nibble first.
// Pops one nibble per clock whenever it is non-empty.
// Assumes DEPTH is a power of two and the writer never pushes more than
// the reported free space.
module trc_nib_fifo
    import trc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int MAX_NIB = ADDR_W / NIB_W,
    localparam int NN_W  = $clog2(MAX_NIB + 1),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NN_W-1:0]   push_n_i,
    input  logic [ADDR_W-1:0] push_data_i,
    output logic [CNT_W-1:0]  free_o,
    output logic [NIB_W-1:0]  head_o
);

    logic [NIB_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             pop;

    // A nibble leaves every cycle the queue holds one.
    always_comb begin
        pop    = (count_q != '0);
        free_o = CNT_W'(DEPTH) - count_q;
        head_o = pop ? mem[rd_ptr_q] : PST_IDLE;
    end

    // Store the pushed nibbles at consecutive slots.
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_NIB; i++) begin
            if (i < int'(push_n_i)) begin
                mem[wr_ptr_q + PTR_W'(i)] <= push_data_i[NIB_W*i +: NIB_W];
            end
        end
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + PTR_W'(push_n_i);
            rd_ptr_q <= rd_ptr_q + PTR_W'(pop);
            count_q  <= count_q + CNT_W'(push_n_i) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R8
    AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n_i != '0) |-> (CNT_W'(push_n_i) <= free_o)); // R8
    AST_ONE_PER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0 && push_n_i == '0) |=> (count_q == $past(count_q) - CNT_W'(1))); // R5

endmodule

// File: rtl/trc_pst_seq.sv
// Status sequencer: chooses the trace code for each cycle and holds a
// computed-branch payload until its marker slot.
// Decides when a payload may be pushed and when the core must stall.
// Assumes the core keeps its event stable while stall_o is high.
module trc_pst_seq
    import trc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int MAX_NIB = ADDR_W / NIB_W,
    localparam int NN_W  = $clog2(MAX_NIB + 1),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_kind_t          kind_i,
    input  logic [NIB_W-1:0]  code_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NN_W-1:0]   cur_nnib_i,
    input  logic [NIB_W-1:0]  cur_mark_i,
    input  logic [CNT_W-1:0]  free_i,
    output logic [NN_W-1:0]   push_n_o,
    output logic [ADDR_W-1:0] push_data_o,
    output logic [NIB_W-1:0]  pst_o,
    output logic              stall_o
);

    logic [NIB_W-1:0]  pst_q;
    logic [NIB_W-1:0]  pst_d;
    logic              pend_q;
    logic [NN_W-1:0]   pend_nnib_q;
    logic [NIB_W-1:0]  pend_mark_q;
    logic [ADDR_W-1:0] pend_data_q;
    logic              pend_fit;
    logic              wr_fit;

    // Room checks against the space free before this cycle's pop.
    always_comb begin
        pend_fit = (CNT_W'(pend_nnib_q) <= free_i);
        wr_fit   = (CNT_W'(cur_nnib_i) <= free_i);
    end

    // Stall while a marker waits, or while a write does not fit.
    always_comb begin
        stall_o = pend_q || (kind_i == EV_DWRITE && !wr_fit);
    end

    // Select the payload to push this cycle, if any.
    always_comb begin
        push_n_o    = '0;
        push_data_o = addr_i;
        if (pend_q) begin
            push_data_o = pend_data_q;
            if (pend_fit) begin
                push_n_o = pend_nnib_q;
            end
        end else if (kind_i == EV_DWRITE && wr_fit) begin
            push_n_o = cur_nnib_i;
        end
    end

    // Next status code.
    always_comb begin
        if (pend_q) begin
            pst_d = pend_fit ? pend_mark_q : PST_IDLE;
        end else begin
            case (kind_i)
                EV_STATUS:  pst_d = code_i;
                EV_BR_FIX:  pst_d = PST_BRANCH;
                EV_BR_COMP: pst_d = PST_BRANCH;
                default:    pst_d = wr_fit ? cur_mark_i : PST_IDLE;
            endcase
        end
    end

    // Register the status code and the pending-marker flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst_q  <= PST_IDLE;
            pend_q <= 1'b0;
        end else begin
            pst_q  <= pst_d;
            pend_q <= pend_q ? !pend_fit : (kind_i == EV_BR_COMP);
        end
    end

    // Capture a computed-branch payload when the branch is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_nnib_q <= '0;
            pend_mark_q <= PST_IDLE;
            pend_data_q <= '0;
        end else if (!pend_q && kind_i == EV_BR_COMP) begin
            pend_nnib_q <= cur_nnib_i;
            pend_mark_q <= cur_mark_i;
            pend_data_q <= addr_i;
        end
    end

    assign pst_o = pst_q;

    AST_MARKER_AFTER_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && pend_fit) |=> (pst_q >= 4'h9 && pst_q <= 4'hB)); // R4
    AST_STALL_SHOWS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && push_n_o == '0) |=> (pst_q == PST_IDLE)); // R8

endmodule

// File: rtl/trc_nib_serializer.sv
// Trace serializer top: status codes on one 4-bit port and queued,
// nibble-serialized payloads on another.
// A core stall is raised when a payload cannot be queued whole.
// Assumes a 32-bit address and one event per cycle from the core.
module trc_nib_serializer
    import trc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int MAX_NIB = ADDR_W / NIB_W,
    localparam int NN_W  = $clog2(MAX_NIB + 1),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ev_kind_i,
    input  logic [3:0]        ev_code_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [1:0]        cfg_tgt_bytes_i,
    input  logic [1:0]        wr_size_i,
    output logic [3:0]        pst_o,
    output logic [3:0]        ddata_o,
    output logic              stall_o
);

    ev_kind_t          kind;
    logic [NN_W-1:0]   cur_nnib;
    logic [NIB_W-1:0]  cur_mark;
    logic [NN_W-1:0]   push_n;
    logic [ADDR_W-1:0] push_data;
    logic [CNT_W-1:0]  free;

    assign kind = ev_kind_t'(ev_kind_i);

    trc_payload_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .kind_i          (kind),
        .cfg_tgt_bytes_i (cfg_tgt_bytes_i),
        .wr_size_i       (wr_size_i),
        .nnib_o          (cur_nnib),
        .marker_o        (cur_mark)
    );

    trc_pst_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind_i      (kind),
        .code_i      (ev_code_i),
        .addr_i      (ev_addr_i),
        .cur_nnib_i  (cur_nnib),
        .cur_mark_i  (cur_mark),
        .free_i      (free),
        .push_n_o    (push_n),
        .push_data_o (push_data),
        .pst_o       (pst_o),
        .stall_o     (stall_o)
    );

    trc_nib_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_n_i    (push_n),
        .push_data_i (push_data),
        .free_o      (free),
        .head_o      (ddata_o)
    );

    AST_FIXED_BRANCH_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && kind == EV_BR_FIX) |-> (push_n == '0)); // R3

endmodule

// File: tb/trc_nib_serializer_tb.sv
module trc_nib_serializer_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ev_kind = 2'd0;
    logic [3:0]  ev_code = 4'h1;
    logic [31:0] ev_addr = '0;
    logic [1:0]  cfg_tb = 2'd0;
    logic [1:0]  wr_size = 2'd0;
    logic [3:0]  pst;
    logic [3:0]  ddata;
    logic        stall;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int          q[$];
    logic [3:0]  m_pst = 4'h0;
    string       m_tag = "R1";
    bit          m_pend = 0;
    int          m_pnib = 0;
    logic [3:0]  m_pmark = 4'h0;
    logic [31:0] m_pdata = '0;

    always #10 clk = ~clk;

    trc_nib_serializer #(.DEPTH(DEPTH), .ADDR_W(32)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ev_kind_i       (ev_kind),
        .ev_code_i       (ev_code),
        .ev_addr_i       (ev_addr),
        .cfg_tgt_bytes_i (cfg_tb),
        .wr_size_i       (wr_size),
        .pst_o           (pst),
        .ddata_o         (ddata),
        .stall_o         (stall)
    );

    function automatic int b_tgt(input logic [1:0] s);
        return (s == 2'd0) ? 2 : (s == 2'd1) ? 3 : 4;
    endfunction

    function automatic int b_wr(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit m_stall();
        return m_pend || (ev_kind == 2'd3 && 2 * b_wr(wr_size) > DEPTH - q.size());
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_push(input logic [31:0] d, input int n);
        for (int i = 0; i < n; i++) q.push_back(int'(d[4*i +: 4]));
    endtask

    // Advance the model by one clock edge using the present inputs.
    task automatic m_step();
        int free;
        int n;
        logic [3:0] np;
        free = DEPTH - q.size();
        if (m_pend) begin
            if (m_pnib <= free) begin
                np = m_pmark; m_tag = "R4"; m_pend = 0;
                if (q.size() > 0) void'(q.pop_front());
                m_push(m_pdata, m_pnib);
            end else begin
                np = 4'h0; m_tag = "R8";
                if (q.size() > 0) void'(q.pop_front());
            end
        end else begin
            if (q.size() > 0) void'(q.pop_front());
            case (ev_kind)
                2'd0: begin np = ev_code; m_tag = "R2"; end
                2'd1: begin np = 4'h5; m_tag = "R3"; end
                2'd2: begin
                    np = 4'h5; m_tag = "R3"; m_pend = 1;
                    m_pnib = 2 * b_tgt(cfg_tb);
                    m_pmark = 4'(7 + b_tgt(cfg_tb));
                    m_pdata = ev_addr;
                end
                default: begin
                    n = 2 * b_wr(wr_size);
                    if (n <= free) begin
                        np = 4'(7 + b_wr(wr_size)); m_tag = "R6";
                        m_push(ev_addr, n);
                    end else begin
                        np = 4'h0; m_tag = "R8";
                    end
                end
            endcase
        end
        m_pst = np;
    endtask

    // Compare the outputs with the model, away from the clock edge.
    task automatic check_outputs();
        check(m_tag, int'(pst), int'(m_pst));
        if (q.size() == 0) check("R9", int'(ddata), 0);
        else if (m_tag == "R2" || m_tag == "R3") check("R7", int'(ddata), q[0]);
        else check("R5", int'(ddata), q[0]);
    endtask

    // One cycle: check at negedge, drive if accepted, check stall, step at posedge.
    task automatic cycle(input bit drive, input logic [1:0] k, input logic [3:0] c,
                         input logic [31:0] a, input logic [1:0] cf, input logic [1:0] sz);
        bit held;
        @(negedge clk);
        check_outputs();
        held = m_stall();
        if (drive && !held) begin
            ev_kind = k; ev_code = c; ev_addr = a; cfg_tb = cf; wr_size = sz;
        end
        #1;
        check(ev_kind == 2'd3 ? "R8" : "R4", int'(stall), int'(m_stall()));
        @(posedge clk);
        m_step();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", int'(pst), 0);
        check("R1", int'(ddata), 0);
        check("R1", int'(stall), 0);
        @(posedge clk);
        m_step();

        // Directed: computed branch with 2-byte target, then idle status.
        cycle(1, 2'd2, 4'h1, 32'h1234ABCD, 2'd0, 2'd0);
        cycle(1, 2'd0, 4'h1, 32'h0, 2'd0, 2'd0);
        @(negedge clk);
        check("R4", int'(pst), 9);   // marker for two bytes
        check("R5", int'(ddata), 4'hD); // low nibble first
        @(posedge clk);
        m_step();
        repeat (6) cycle(1, 2'd0, 4'h2, 32'h0, 2'd0, 2'd0);

        // Directed: fixed branch queues nothing.
        cycle(1, 2'd1, 4'h0, 32'hFFFF_FFFF, 2'd2, 2'd0);
        cycle(1, 2'd0, 4'h3, 32'h0, 2'd0, 2'd0);
        @(negedge clk);
        check("R3", int'(ddata), 0);
        @(posedge clk);
        m_step();

        // Directed: back-to-back 4-byte writes fill the queue and stall.
        repeat (4) cycle(1, 2'd3, 4'h0, 32'h8765_4321, 2'd0, 2'd2);
        cycle(1, 2'd2, 4'h0, 32'hCAFE_F00D, 2'd3, 2'd0);
        cycle(1, 2'd3, 4'h0, 32'h0000_00A5, 2'd0, 2'd0);
        repeat (20) cycle(1, 2'd0, 4'h4, 32'h0, 2'd0, 2'd0);

        // Random mix of all event kinds and sizes.
        for (int t = 0; t < 4000; t++) begin
            cycle(1, 2'($urandom_range(0, 3)), 4'($urandom), $urandom,
                  2'($urandom), 2'($urandom));
        end
        repeat (30) cycle(1, 2'd0, 4'h1, 32'h0, 2'd0, 2'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule